// File: doc/BRIEF.md
# DDR Bitslip Word Aligner

This block sits behind a serial-to-parallel converter and re-orders the bits of each parallel word so that word boundaries can be moved until they line up with the transmitted framing. Each incoming word is rotated by a stored amount and registered to the output. A single-cycle slip request changes that stored amount. In the default double-data-rate mode the change alternates: one request gives a 1-bit right rotation, the next a 3-bit left rotation, then back to the right step. A single-data-rate build steps right by one bit every time.

An optional training loop compares each settled output word with a programmed pattern. On a mismatch it issues a slip by itself. After each rotation change it waits for the output to settle. It raises a lock flag once enough consecutive words match. External slip requests share the same path as the trainer's own requests.

Top module: `bitslip_aligner`

## Requirements
- R1: After reset `out_valid` and `locked` are 0 and `out_word` is all zeros. The stored rotation is zero, and the next double-data-rate step is the right step.
- R2: Each cycle `out_valid` equals the previous cycle's `in_valid`. When valid, `out_word` is the previous cycle's `in_word` rotated right by the stored amount r, meaning output bit i equals input bit (i+r) mod W.
- R3: With DDR_MODE=1, steps alternate. Odd-numbered applied slips since reset add 1 to r. Even-numbered ones add W-3 to r, which is a left rotation by 3. All arithmetic is mod W.
- R4: With DDR_MODE=0, every applied slip adds 1 to r (mod W).
- R5: A slip request accepted in a cycle leaves r unchanged for the word taken in that cycle and for the words taken on the next two valid cycles. The word after those uses the new r.
- R6: Slip requests that arrive while an accepted slip is still pending are dropped and never applied.
- R7: When `train_en` is 1 and a compared output word differs from `train_pattern`, the block issues a slip itself. After every rotation change it skips the next 4 valid output words before comparing again.
- R8: `locked` rises on the cycle after the 8th consecutive compared output word equal to `train_pattern`.
- R9: `locked` falls on the cycle after a compared mismatch, after an accepted slip, or after `train_en` is low.
- R10: Reset restarts the double-data-rate sequence, so the first slip after reset is the right step again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | W | Parallel word from the deserializer |
| in_valid | input | 1 | in_word is valid this cycle |
| slip_req | input | 1 | Single-cycle request to change the rotation |
| train_en | input | 1 | Enables the training comparator |
| train_pattern | input | W | Word the trainer aligns to |
| out_word | output | W | Rotated, registered word |
| out_valid | output | 1 | out_word is valid |
| locked | output | 1 | Training has matched the pattern |

## Verification
Three latencies are checked, each counted from the edge where its cause is registered:
- **Output word:** appears one edge after the input is taken.
- **Rotation change:** a slip accepted at an edge leaves the next two valid words unchanged, and the third word carries the new rotation.
- **Lock flag:** moves one edge after the deciding compared word. During training, lock must therefore come exactly 11 matching outputs after the last mismatch (3 settle words plus 8 compared words).

Every input is driven at the falling edge and every output is read at the following falling edge. Each check therefore lines up with one counted register stage.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    // Which double-data-rate step the next applied slip performs.
    typedef enum logic {
        STEP_RIGHT1 = 1'b0,
        STEP_LEFT3  = 1'b1
    } step_e;

    localparam int unsigned BSA_DEF_WIDTH  = 8;
    localparam int unsigned BSA_DEF_SETTLE = 4;
    localparam int unsigned BSA_DEF_MATCH  = 8;
    localparam int unsigned BSA_DEF_LAT    = 2;

endpackage

// File: rtl/bsa_rotator.sv
module bsa_rotator #(
    parameter int unsigned W  = 8,
    parameter int unsigned RW = $clog2(W)
) (
    input  logic [W-1:0]  word_i,
    input  logic [RW-1:0] rot_i,
    output logic [W-1:0]  word_o
);

    // Right rotation: output bit g takes input bit (g + rot) mod W.
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [RW:0]   sum;
        logic [RW:0]   idx;

        always_comb begin
            sum = {1'b0, rot_i} + (RW+1)'(g);
            if (sum >= (RW+1)'(W)) begin
                idx = sum - (RW+1)'(W);
            end else begin
                idx = sum;
            end
        end

        assign word_o[g] = word_i[idx[RW-1:0]];
    end

endmodule

// File: rtl/bsa_slip_ctrl.sv
module bsa_slip_ctrl
    import bsa_pkg::*;
#(
    parameter int unsigned W        = 8,
    parameter bit          DDR_MODE = 1'b1,
    parameter int unsigned SLIP_LAT = 2,
    parameter int unsigned RW       = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic          slip_i,
    output logic [RW-1:0] rot_o,
    output logic          busy_o,
    output logic          accept_o,
    output logic          update_o,
    output logic          step_left_o
);

    localparam int unsigned PW = $clog2(SLIP_LAT + 1);

    typedef struct packed {
        logic [RW-1:0] rot;
        logic [PW-1:0] pend;
        step_e         step;
    } slip_st_t;

    slip_st_t st_d, st_q;
    logic [RW-1:0] rot_next;
    step_e         step_next;

    // Mode variant: double-data-rate alternates +1 / +(W-3), single steps +1.
    if (DDR_MODE) begin : g_ddr
        localparam logic [RW:0] AMT_R = (RW+1)'(1);
        localparam logic [RW:0] AMT_L = (RW+1)'(W - 3);
        logic [RW:0] sum;
        always_comb begin
            sum = {1'b0, st_q.rot} + ((st_q.step == STEP_LEFT3) ? AMT_L : AMT_R);
            if (sum >= (RW+1)'(W)) begin
                sum = sum - (RW+1)'(W);
            end
            rot_next  = sum[RW-1:0];
            step_next = (st_q.step == STEP_LEFT3) ? STEP_RIGHT1 : STEP_LEFT3;
        end
    end else begin : g_sdr
        logic [RW:0] sum;
        always_comb begin
            sum = {1'b0, st_q.rot} + (RW+1)'(1);
            if (sum >= (RW+1)'(W)) begin
                sum = sum - (RW+1)'(W);
            end
            rot_next  = sum[RW-1:0];
            step_next = STEP_RIGHT1;
        end
    end

    always_comb begin
        st_d     = st_q;
        accept_o = 1'b0;
        update_o = 1'b0;
        if (st_q.pend == '0) begin
            if (slip_i) begin
                st_d.pend = PW'(SLIP_LAT);
                accept_o  = 1'b1;
            end
        end else if (valid_i) begin
            st_d.pend = st_q.pend - PW'(1);
            if (st_q.pend == PW'(1)) begin
                st_d.rot  = rot_next;
                st_d.step = step_next;
                update_o  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rot: '0, pend: '0, step: STEP_RIGHT1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rot_o       = st_q.rot;
    assign busy_o      = (st_q.pend != '0);
    assign step_left_o = (st_q.step == STEP_LEFT3);

endmodule

// File: rtl/bsa_trainer.sv
module bsa_trainer #(
    parameter int unsigned W       = 8,
    parameter int unsigned SETTLE  = 4,
    parameter int unsigned MATCH_N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         train_en_i,
    input  logic [W-1:0] pattern_i,
    input  logic         out_valid_i,
    input  logic [W-1:0] out_word_i,
    input  logic         busy_i,
    input  logic         accept_i,
    input  logic         update_i,
    output logic         slip_o,
    output logic         locked_o
);

    localparam int unsigned SW = $clog2(SETTLE + 1);
    localparam int unsigned MW = (MATCH_N > 1) ? $clog2(MATCH_N) : 1;

    typedef struct packed {
        logic [SW-1:0] settle;
        logic [MW-1:0] mcnt;
        logic          locked;
    } trn_st_t;

    trn_st_t st_d, st_q;
    logic    compare;
    logic    match;

    always_comb begin
        st_d    = st_q;
        compare = train_en_i && out_valid_i && (st_q.settle == '0) && !busy_i;
        match   = (out_word_i == pattern_i);
        slip_o  = compare && !match;

        if (update_i) begin
            st_d.settle = SW'(SETTLE);
        end else if (out_valid_i && (st_q.settle != '0)) begin
            st_d.settle = st_q.settle - SW'(1);
        end

        if (!train_en_i || accept_i) begin
            st_d.locked = 1'b0;
            st_d.mcnt   = '0;
        end else if (compare) begin
            if (!match) begin
                st_d.locked = 1'b0;
                st_d.mcnt   = '0;
            end else if (st_q.mcnt == MW'(MATCH_N - 1)) begin
                st_d.locked = 1'b1;
            end else begin
                st_d.mcnt = st_q.mcnt + MW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked_o = st_q.locked;

endmodule

// File: rtl/bitslip_aligner.sv
module bitslip_aligner
    import bsa_pkg::*;
#(
    parameter int unsigned W        = BSA_DEF_WIDTH,
    parameter bit          DDR_MODE = 1'b1,
    parameter int unsigned SLIP_LAT = BSA_DEF_LAT,
    parameter int unsigned SETTLE   = BSA_DEF_SETTLE,
    parameter int unsigned MATCH_N  = BSA_DEF_MATCH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_word,
    input  logic         in_valid,
    input  logic         slip_req,
    input  logic         train_en,
    input  logic [W-1:0] train_pattern,
    output logic [W-1:0] out_word,
    output logic         out_valid,
    output logic         locked
);

    localparam int unsigned RW = $clog2(W);

    typedef struct packed {
        logic [W-1:0] word;
        logic         valid;
    } out_st_t;

    out_st_t       out_d, out_q;
    logic [RW-1:0] rot_w;
    logic          busy_w;
    logic          accept_w;
    logic          update_w;
    logic          step_left_w;
    logic          trn_slip_w;
    logic          slip_any_w;
    logic [W-1:0]  rot_word_w;

    assign slip_any_w = slip_req | trn_slip_w;

    bsa_slip_ctrl #(
        .W(W), .DDR_MODE(DDR_MODE), .SLIP_LAT(SLIP_LAT)
    ) slip_i (
        .clk(clk), .rst_n(rst_n), .valid_i(in_valid), .slip_i(slip_any_w),
        .rot_o(rot_w), .busy_o(busy_w), .accept_o(accept_w),
        .update_o(update_w), .step_left_o(step_left_w)
    );

    bsa_rotator #(.W(W)) rot_i (
        .word_i(in_word), .rot_i(rot_w), .word_o(rot_word_w)
    );

    bsa_trainer #(
        .W(W), .SETTLE(SETTLE), .MATCH_N(MATCH_N)
    ) trn_i (
        .clk(clk), .rst_n(rst_n), .train_en_i(train_en),
        .pattern_i(train_pattern), .out_valid_i(out_q.valid),
        .out_word_i(out_q.word), .busy_i(busy_w), .accept_i(accept_w),
        .update_i(update_w), .slip_o(trn_slip_w), .locked_o(locked)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = in_valid;
        if (in_valid) begin
            out_d.word = rot_word_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_word  = out_q.word;
    assign out_valid = out_q.valid;

endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
    parameter int unsigned W        = 8,
    parameter bit          DDR_MODE = 1'b1,
    parameter int unsigned RW       = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          out_valid,
    input  logic [W-1:0]  out_word,
    input  logic [W-1:0]  pattern,
    input  logic          train_en,
    input  logic          locked,
    input  logic          busy,
    input  logic [RW-1:0] rot,
    input  logic          step_left
);

    assert_valid_pipe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_invalid_pipe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_while_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !in_valid) |=> $stable(rot));

    assert_idle_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(rot));

    assert_step_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rot != $past(rot)) |->
            (int'(rot) == ((int'($past(rot)) +
                ((DDR_MODE && $past(step_left)) ? (W - 3) : 1)) % W)));

    assert_step_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (DDR_MODE && (rot != $past(rot))) |-> (step_left != $past(step_left)));

    assert_lock_after_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(out_valid && (out_word == pattern)));

    assert_unlock_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !train_en |=> !locked);

endmodule

bind bitslip_aligner bsa_checker #(.W(W), .DDR_MODE(DDR_MODE)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_word(out_word), .pattern(train_pattern), .train_en(train_en),
    .locked(locked), .busy(busy_w), .rot(rot_w), .step_left(step_left_w)
);

// File: tb/bitslip_aligner_tb_top.sv
module bitslip_aligner_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] in_word;
    logic         in_valid;
    logic         slip_req;
    logic         train_en;
    logic [W-1:0] train_pattern;
    logic [W-1:0] out_word, sdr_word;
    logic         out_valid, sdr_valid;
    logic         locked, sdr_locked;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int net_ddr, net_sdr;
    bit ddr_left;

    always #10 clk = ~clk;

    bitslip_aligner #(.W(W), .DDR_MODE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
        .slip_req(slip_req), .train_en(train_en), .train_pattern(train_pattern),
        .out_word(out_word), .out_valid(out_valid), .locked(locked)
    );

    bitslip_aligner #(.W(W), .DDR_MODE(1'b0)) dut_sdr_i (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
        .slip_req(slip_req), .train_en(1'b0), .train_pattern(train_pattern),
        .out_word(sdr_word), .out_valid(sdr_valid), .locked(sdr_locked)
    );

    // Table: {slip before this word, word}
    localparam logic [W:0] VEC [8] = '{
        {1'b0, 8'h01}, {1'b1, 8'h01}, {1'b1, 8'h96}, {1'b0, 8'h3C},
        {1'b1, 8'h80}, {1'b1, 8'hA7}, {1'b0, 8'h5B}, {1'b1, 8'h0F}
    };

    function automatic logic [W-1:0] ror(logic [W-1:0] w, int r);
        logic [W-1:0] o;
        for (int i = 0; i < W; i++) o[i] = w[(i + r) % W];
        return o;
    endfunction

    task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_slip();
        net_ddr  = (net_ddr + (ddr_left ? W - 3 : 1)) % W;
        ddr_left = !ddr_left;
        net_sdr  = (net_sdr + 1) % W;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_word = '0; in_valid = 1'b0; slip_req = 1'b0;
        train_en = 1'b0; train_pattern = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        net_ddr = 0; net_sdr = 0; ddr_left = 1'b0;
    endtask

    task automatic pulse_slip();
        slip_req = 1'b1; in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        slip_req = 1'b0;
    endtask

    task automatic send(logic [W-1:0] w, string req);
        in_word = w; in_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_word == ror(w, net_ddr), req, out_word, ror(w, net_ddr));
        chk(sdr_valid && sdr_word == ror(w, net_sdr), req, sdr_word, ror(w, net_sdr));
    endtask

    // Run the trainer until locked; returns matching-output run length at lock.
    task automatic train_until_lock(logic [W-1:0] w, output int run, output bit got);
        run = 0; got = 1'b0;
        in_word = w; in_valid = 1'b1; train_en = 1'b1;
        for (int c = 0; c < 400; c++) begin
            @(posedge clk); @(negedge clk);
            if (locked) begin
                got = 1'b1;
                break;
            end
            if (out_valid && out_word == train_pattern) run++;
            else run = 0;
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int  run;
        bit  got;

        // R1: reset state
        do_reset();
        chk(!out_valid && !locked, "R1 flags", {6'b0, out_valid, locked}, '0);
        chk(out_word == '0, "R1 word", out_word, '0);
        send(8'h81, "R1 zero rotation");

        // Table walk: R2, R3, R4, R5
        for (int k = 0; k < 8; k++) begin
            if (VEC[k][W]) begin
                pulse_slip();
                send(VEC[k][W-1:0], "R5 old rotation first");
                send(VEC[k][W-1:0], "R5 old rotation second");
                model_slip();
                send(VEC[k][W-1:0], "R3/R4 new rotation");
            end else begin
                send(VEC[k][W-1:0], "R2 steady rotation");
            end
        end

        // R10: reset restarts at the right step
        do_reset();
        pulse_slip();
        send(8'h03, "R10 pending");
        send(8'h03, "R10 pending");
        model_slip();
        send(8'h03, "R10 first step is right 1");
        chk(out_word == ror(8'h03, 1), "R10 explicit", out_word, ror(8'h03, 1));

        // R6: second request during the pending window is dropped
        do_reset();
        pulse_slip();
        pulse_slip();
        send(8'h11, "R6 pending");
        send(8'h11, "R6 pending");
        model_slip();
        send(8'h11, "R6 single step");
        send(8'h11, "R6 no late step");
        send(8'h11, "R6 no late step");

        // R7, R8: training locks after 3 settle words plus 8 compared matches
        do_reset();
        train_pattern = ror(8'h03, 4);
        train_until_lock(8'h03, run, got);
        chk(got, "R7 trainer reaches lock", {7'b0, got}, 8'h01);
        chk(run == 11, "R8 lock after 8 compared matches", W'(run), 8'd11);
        chk(out_word == train_pattern, "R8 output equals pattern", out_word, train_pattern);

        // R9: mismatch clears lock one cycle later
        in_word = 8'hF0;
        @(posedge clk); @(negedge clk);
        chk(locked, "R9 lock holds until mismatch seen", {7'b0, locked}, 8'h01);
        in_word = 8'h03;
        @(posedge clk); @(negedge clk);
        chk(!locked, "R9 mismatch clears lock", {7'b0, locked}, 8'h00);

        // R9: train_en low clears lock
        do_reset();
        train_pattern = ror(8'h03, 4);
        train_until_lock(8'h03, run, got);
        chk(got, "R7 relock", {7'b0, got}, 8'h01);
        train_en = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(!locked, "R9 disable clears lock", {7'b0, locked}, 8'h00);

        // R9: accepted external slip clears lock
        do_reset();
        train_pattern = ror(8'h03, 4);
        train_until_lock(8'h03, run, got);
        chk(got, "R7 relock", {7'b0, got}, 8'h01);
        slip_req = 1'b1;
        @(posedge clk); @(negedge clk);
        slip_req = 1'b0;
        chk(!locked, "R9 slip clears lock", {7'b0, locked}, 8'h00);

        in_valid = 1'b0; train_en = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule